// File: doc/BRIEF.md
# Snoop-Inhibit Memory Response Controller

This block sits on the memory side of a snooping split-transaction bus. It decides, for every read or read-exclusive request, whether main memory or a cache that holds the line dirty ends up supplying the data. Memory starts its fetch as soon as a data-bearing request is seen. It does not commit to driving the data bus until the inhibit snoop line is low. A cache that owns the line modified holds inhibit up until it wins the data bus. It then drops inhibit, raises the modified line and flushes the line itself.

Each outstanding transaction is tracked in a slot indexed by its response tag. When a flush with the modified line high carries the tag of a pending slot, the controller cancels its own response for that tag. For a plain read, it also writes the flushed beats into memory. For a read-exclusive it discards them. Otherwise, once the fetch reports ready and inhibit is low, the controller requests the data bus. When granted, it drives the line as a burst of beats followed by a turnaround gap.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is low.
- R2: A request with command 1 (read) or 2 (read-exclusive) raises `fetch_start` with `fetch_tag` equal to the request tag in the cycle after the request edge. Command 0 (idle) or 3 (upgrade) starts no fetch and no slot.
- R3: `dbus_req` is high only in a cycle that follows an edge at which inhibit was low and `bus_dvalid` was low. A pending request is withdrawn at the edge where inhibit or `bus_dvalid` is seen high.
- R4: A slot cannot ask for the bus until one snoop cycle has passed after its request edge and its fetch has reported ready through `mem_rdy` with its tag.
- R5: An edge with `dbus_req` and `dbus_grant` both high (and inhibit and `bus_dvalid` low) is followed by `LINE_BYTES*8/DATA_W` consecutive drive cycles (4 by default). These carry beats 0,1,2,3 in order and the granted tag on `drive_tag`.
- R6: After the last beat of a burst, `TURN_CYC` cycles (1 by default) pass with neither `dbus_req` nor `dbus_drive` high.
- R7: A data-bus beat seen with `bus_dvalid` and `snp_modified` high, whose `bus_dtag` names a pending slot, raises `fetch_abort` with that tag in the next cycle. Memory then never drives that tag's response.
- R8: When the aborted slot was a read, each flushed beat produces a `mem_wr` pulse one cycle later. Each pulse carries the slot tag and beat numbers 0 to 3 in arrival order.
- R9: When the aborted slot was a read-exclusive, no `mem_wr` pulse is produced for the flush.
- R10: When several slots are ready, the lowest tag is served first.
- R11: The shared snoop line has no effect on any output.
- R12: A modified flush whose tag names no pending slot produces no abort and no memory write.
- R13: `mem_rdy` for a tag with no pending slot is ignored: no bus request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is on the address bus |
| req_cmd | input | 2 | 0 idle, 1 read, 2 read-exclusive, 3 upgrade |
| req_tag | input | TAG_W | Response tag of the request |
| snp_shared | input | 1 | Wired-OR shared snoop line |
| snp_modified | input | 1 | Wired-OR modified snoop line |
| snp_inhibit | input | 1 | Wired-OR inhibit snoop line |
| mem_rdy | input | 1 | Memory fetch for `mem_rdy_tag` is complete |
| mem_rdy_tag | input | TAG_W | Tag of the completed fetch |
| dbus_grant | input | 1 | Data-bus grant to memory |
| bus_dvalid | input | 1 | Another agent drives a data beat |
| bus_dtag | input | TAG_W | Tag carried with that beat |
| dbus_req | output | 1 | Memory requests the data bus |
| dbus_drive | output | 1 | Memory drives a data beat |
| drive_tag | output | TAG_W | Tag of the beat memory drives |
| drive_beat | output | BEAT_W | Beat index memory drives |
| fetch_start | output | 1 | Start a memory fetch |
| fetch_tag | output | TAG_W | Tag of the fetch to start |
| fetch_abort | output | 1 | Cancel the memory response |
| abort_tag | output | TAG_W | Tag of the cancelled response |
| mem_wr | output | 1 | Write one captured beat into memory |
| mem_wr_tag | output | TAG_W | Tag of the captured line |
| mem_wr_beat | output | BEAT_W | Beat index of the captured beat |

## Verification
Every output is a register or a decode of registers, so each result falls due exactly one clock after the edge that causes it. Fetch start, abort and each captured write follow their triggering edge by one cycle. A bus request follows the edge that saw a ready slot with inhibit low, and the first drive beat follows the grant edge. The bench drives inputs on the falling edge and advances a behavioural model on every rising edge from the sampled inputs. It compares all outputs against that model on the next falling edge, so each comparison lands in the cycle the result is due. Scenario counters then confirm burst lengths, serving order and the absence of writes or aborts where none may occur.

// File: rtl/snoop_resp_pkg.sv
package snoop_resp_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_READ  = 2'd1,
      CMD_READX = 2'd2,
      CMD_UPGR  = 2'd3
   } bus_cmd_e;

   typedef enum logic [1:0] {
      SLOT_FREE   = 2'd0,
      SLOT_SETTLE = 2'd1,
      SLOT_FETCH  = 2'd2,
      SLOT_READY  = 2'd3
   } slot_state_e;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_REQ   = 2'd1,
      ENG_DRIVE = 2'd2,
      ENG_TURN  = 2'd3
   } eng_state_e;

   function automatic logic cmd_has_data(input logic [1:0] cmd);
      return (cmd == CMD_READ) || (cmd == CMD_READX);
   endfunction

endpackage

// File: rtl/snoop_slot_table.sv
module snoop_slot_table
   import snoop_resp_pkg::*;
#(
   parameter int TAG_W = 3,
   localparam int NUM_TAGS = 1 << TAG_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_valid,
   input  logic [TAG_W-1:0]    alloc_tag,
   input  logic                alloc_read,
   input  logic                rdy_valid,
   input  logic [TAG_W-1:0]    rdy_tag,
   input  logic                kill_valid,
   input  logic [TAG_W-1:0]    kill_tag,
   input  logic                serve_valid,
   input  logic [TAG_W-1:0]    serve_tag,
   output logic [NUM_TAGS-1:0] slot_ready,
   output logic [NUM_TAGS-1:0] slot_busy,
   output logic [NUM_TAGS-1:0] slot_read
);

   for (genvar gi = 0; gi < NUM_TAGS; gi++) begin : g_slot
      slot_state_e st_q;
      slot_state_e st_d;
      logic        rd_q;
      logic        hit_alloc;
      logic        hit_rdy;
      logic        hit_kill;
      logic        hit_serve;

      assign hit_alloc = alloc_valid && (alloc_tag == TAG_W'(gi));
      assign hit_rdy   = rdy_valid   && (rdy_tag   == TAG_W'(gi));
      assign hit_kill  = kill_valid  && (kill_tag  == TAG_W'(gi));
      assign hit_serve = serve_valid && (serve_tag == TAG_W'(gi));

      always_comb begin
         st_d = st_q;
         if (hit_kill && (st_q != SLOT_FREE)) begin
            st_d = SLOT_FREE;
         end else begin
            unique case (st_q)
               SLOT_FREE:   if (hit_alloc) st_d = SLOT_SETTLE;
               SLOT_SETTLE: st_d = hit_rdy ? SLOT_READY : SLOT_FETCH;
               SLOT_FETCH:  if (hit_rdy) st_d = SLOT_READY;
               SLOT_READY:  if (hit_serve) st_d = SLOT_FREE;
               default:     st_d = SLOT_FREE;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q <= SLOT_FREE;
            rd_q <= 1'b0;
         end else begin
            st_q <= st_d;
            if ((st_q == SLOT_FREE) && hit_alloc) rd_q <= alloc_read;
         end
      end

      assign slot_ready[gi] = (st_q == SLOT_READY);
      assign slot_busy[gi]  = (st_q != SLOT_FREE);
      assign slot_read[gi]  = rd_q;
   end

endmodule

// File: rtl/snoop_resp_engine.sv
module snoop_resp_engine
   import snoop_resp_pkg::*;
#(
   parameter int TAG_W    = 3,
   parameter int BEATS    = 4,
   parameter int TURN_CYC = 1,
   localparam int NUM_TAGS = 1 << TAG_W,
   localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1,
   localparam int TURN_W   = (TURN_CYC > 1) ? $clog2(TURN_CYC) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TAGS-1:0] slot_ready,
   input  logic                snp_inhibit,
   input  logic                bus_dvalid,
   input  logic                dbus_grant,
   output logic                dbus_req,
   output logic                dbus_drive,
   output logic [TAG_W-1:0]    drive_tag,
   output logic [BEAT_W-1:0]   drive_beat,
   output logic                serve_valid,
   output logic [TAG_W-1:0]    serve_tag
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
   localparam logic [TURN_W-1:0] LAST_TURN = TURN_W'((TURN_CYC > 0) ? TURN_CYC - 1 : 0);

   eng_state_e         st_q;
   logic [TAG_W-1:0]   tag_q;
   logic [BEAT_W-1:0]  beat_q;
   logic [TURN_W-1:0]  turn_q;
   logic               any_ready;
   logic [TAG_W-1:0]   pick;
   logic               bus_quiet;
   logic               last_beat;
   eng_state_e         after_burst;

   // lowest ready tag wins
   always_comb begin
      pick = '0;
      for (int i = NUM_TAGS - 1; i >= 0; i--) begin
         if (slot_ready[i]) pick = TAG_W'(i);
      end
   end

   assign any_ready = |slot_ready;
   assign bus_quiet = !snp_inhibit && !bus_dvalid;
   assign last_beat = (st_q == ENG_DRIVE) && (beat_q == LAST_BEAT);

   if (TURN_CYC > 0) begin : g_turn
      assign after_burst = ENG_TURN;
   end else begin : g_no_turn
      assign after_burst = ENG_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ENG_IDLE;
         tag_q  <= '0;
         beat_q <= '0;
         turn_q <= '0;
      end else begin
         unique case (st_q)
            ENG_IDLE: begin
               if (any_ready && bus_quiet) begin
                  st_q  <= ENG_REQ;
                  tag_q <= pick;
               end
            end
            ENG_REQ: begin
               if (!bus_quiet) begin
                  st_q <= ENG_IDLE;
               end else if (dbus_grant) begin
                  st_q   <= ENG_DRIVE;
                  beat_q <= '0;
               end
            end
            ENG_DRIVE: begin
               if (last_beat) begin
                  st_q   <= after_burst;
                  turn_q <= '0;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            ENG_TURN: begin
               if (turn_q == LAST_TURN) st_q <= ENG_IDLE;
               else                     turn_q <= turn_q + 1'b1;
            end
            default: st_q <= ENG_IDLE;
         endcase
      end
   end

   assign dbus_req    = (st_q == ENG_REQ);
   assign dbus_drive  = (st_q == ENG_DRIVE);
   assign drive_tag   = tag_q;
   assign drive_beat  = beat_q;
   assign serve_valid = last_beat;
   assign serve_tag   = tag_q;

endmodule

// File: rtl/snoop_flush_capture.sv
module snoop_flush_capture #(
   parameter int TAG_W = 3,
   parameter int BEATS = 4,
   localparam int NUM_TAGS = 1 << TAG_W,
   localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_dvalid,
   input  logic [TAG_W-1:0]    bus_dtag,
   input  logic                snp_modified,
   input  logic [NUM_TAGS-1:0] slot_busy,
   input  logic [NUM_TAGS-1:0] slot_read,
   output logic                kill_valid,
   output logic [TAG_W-1:0]    kill_tag,
   output logic                fetch_abort,
   output logic [TAG_W-1:0]    abort_tag,
   output logic                mem_wr,
   output logic [TAG_W-1:0]    mem_wr_tag,
   output logic [BEAT_W-1:0]   mem_wr_beat
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
   localparam bit MULTI_BEAT = (BEATS > 1);

   logic              act_q;
   logic              wr_q;
   logic [TAG_W-1:0]  tag_q;
   logic [BEAT_W-1:0] cnt_q;
   logic              start;

   assign start      = !act_q && bus_dvalid && snp_modified && slot_busy[bus_dtag];
   assign kill_valid = start;
   assign kill_tag   = bus_dtag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q       <= 1'b0;
         wr_q        <= 1'b0;
         tag_q       <= '0;
         cnt_q       <= '0;
         fetch_abort <= 1'b0;
         abort_tag   <= '0;
         mem_wr      <= 1'b0;
         mem_wr_tag  <= '0;
         mem_wr_beat <= '0;
      end else begin
         fetch_abort <= start;
         mem_wr      <= 1'b0;
         if (start) begin
            act_q       <= MULTI_BEAT;
            wr_q        <= slot_read[bus_dtag];
            tag_q       <= bus_dtag;
            cnt_q       <= BEAT_W'(1);
            abort_tag   <= bus_dtag;
            mem_wr      <= slot_read[bus_dtag];
            mem_wr_tag  <= bus_dtag;
            mem_wr_beat <= '0;
         end else if (act_q && bus_dvalid) begin
            mem_wr      <= wr_q;
            mem_wr_tag  <= tag_q;
            mem_wr_beat <= cnt_q;
            if (cnt_q == LAST_BEAT) act_q <= 1'b0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/snoop_resp_ctrl.sv
module snoop_resp_ctrl
   import snoop_resp_pkg::*;
#(
   parameter int TAG_W      = 3,
   parameter int DATA_W     = 256,
   parameter int LINE_BYTES = 128,
   parameter int TURN_CYC   = 1,
   localparam int NUM_TAGS  = 1 << TAG_W,
   localparam int LINE_BITS = LINE_BYTES * 8,
   localparam int BEATS     = LINE_BITS / DATA_W,
   localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_cmd,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic              snp_shared,
   input  logic              snp_modified,
   input  logic              snp_inhibit,
   input  logic              mem_rdy,
   input  logic [TAG_W-1:0]  mem_rdy_tag,
   input  logic              dbus_grant,
   input  logic              bus_dvalid,
   input  logic [TAG_W-1:0]  bus_dtag,
   output logic              dbus_req,
   output logic              dbus_drive,
   output logic [TAG_W-1:0]  drive_tag,
   output logic [BEAT_W-1:0] drive_beat,
   output logic              fetch_start,
   output logic [TAG_W-1:0]  fetch_tag,
   output logic              fetch_abort,
   output logic [TAG_W-1:0]  abort_tag,
   output logic              mem_wr,
   output logic [TAG_W-1:0]  mem_wr_tag,
   output logic [BEAT_W-1:0] mem_wr_beat
);

   if (TAG_W < 1 || TAG_W > 8) begin : g_bad_tag
      $error("snoop_resp_ctrl: TAG_W must lie in 1..8");
   end
   if (DATA_W < 8 || (LINE_BITS % DATA_W) != 0 || BEATS < 1) begin : g_bad_width
      $error("snoop_resp_ctrl: line size must be a whole number of data beats");
   end
   if (TURN_CYC < 0) begin : g_bad_turn
      $error("snoop_resp_ctrl: TURN_CYC must not be negative");
   end

   logic                alloc_valid;
   logic                kill_valid;
   logic [TAG_W-1:0]    kill_tag;
   logic                serve_valid;
   logic [TAG_W-1:0]    serve_tag;
   logic [NUM_TAGS-1:0] slot_ready;
   logic [NUM_TAGS-1:0] slot_busy;
   logic [NUM_TAGS-1:0] slot_read;
   logic                shared_unused;

   // the shared line carries no meaning for the memory side
   assign shared_unused = snp_shared;
   assign alloc_valid   = req_valid && cmd_has_data(req_cmd);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_start <= 1'b0;
         fetch_tag   <= '0;
      end else begin
         fetch_start <= alloc_valid;
         fetch_tag   <= req_tag;
      end
   end

   snoop_slot_table #(.TAG_W(TAG_W)) u_slots (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_valid (alloc_valid),
      .alloc_tag   (req_tag),
      .alloc_read  (req_cmd == CMD_READ),
      .rdy_valid   (mem_rdy),
      .rdy_tag     (mem_rdy_tag),
      .kill_valid  (kill_valid),
      .kill_tag    (kill_tag),
      .serve_valid (serve_valid),
      .serve_tag   (serve_tag),
      .slot_ready  (slot_ready),
      .slot_busy   (slot_busy),
      .slot_read   (slot_read)
   );

   snoop_resp_engine #(.TAG_W(TAG_W), .BEATS(BEATS), .TURN_CYC(TURN_CYC)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_ready  (slot_ready),
      .snp_inhibit (snp_inhibit),
      .bus_dvalid  (bus_dvalid),
      .dbus_grant  (dbus_grant),
      .dbus_req    (dbus_req),
      .dbus_drive  (dbus_drive),
      .drive_tag   (drive_tag),
      .drive_beat  (drive_beat),
      .serve_valid (serve_valid),
      .serve_tag   (serve_tag)
   );

   snoop_flush_capture #(.TAG_W(TAG_W), .BEATS(BEATS)) u_capture (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_dvalid   (bus_dvalid),
      .bus_dtag     (bus_dtag),
      .snp_modified (snp_modified),
      .slot_busy    (slot_busy),
      .slot_read    (slot_read),
      .kill_valid   (kill_valid),
      .kill_tag     (kill_tag),
      .fetch_abort  (fetch_abort),
      .abort_tag    (abort_tag),
      .mem_wr       (mem_wr),
      .mem_wr_tag   (mem_wr_tag),
      .mem_wr_beat  (mem_wr_beat)
   );

endmodule

// File: rtl/snoop_resp_ctrl_chk.sv
module snoop_resp_ctrl_chk #(
   parameter int TAG_W  = 3,
   parameter int BEAT_W = 2,
   parameter int BEATS  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_cmd,
   input logic              snp_inhibit,
   input logic              bus_dvalid,
   input logic              dbus_grant,
   input logic              dbus_req,
   input logic              dbus_drive,
   input logic [BEAT_W-1:0] drive_beat,
   input logic              fetch_start,
   input logic              mem_wr
);

   p_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_start |-> $past(req_valid) && ($past(req_cmd) == 2'd1 || $past(req_cmd) == 2'd2));

   p_quiet_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dbus_req |-> !$past(snp_inhibit) && !$past(bus_dvalid));

   p_burst_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dbus_req && dbus_grant && !snp_inhibit && !bus_dvalid |=> dbus_drive && drive_beat == '0);

   p_burst_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dbus_drive && drive_beat != BEAT_W'(BEATS - 1) |=> dbus_drive && drive_beat == $past(drive_beat) + 1'b1);

   p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dbus_drive) |-> !dbus_req && !dbus_drive);

   p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dbus_req, dbus_drive}));

   p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> $past(bus_dvalid));

endmodule

bind snoop_resp_ctrl snoop_resp_ctrl_chk #(.TAG_W(TAG_W), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_cmd     (req_cmd),
   .snp_inhibit (snp_inhibit),
   .bus_dvalid  (bus_dvalid),
   .dbus_grant  (dbus_grant),
   .dbus_req    (dbus_req),
   .dbus_drive  (dbus_drive),
   .drive_beat  (drive_beat),
   .fetch_start (fetch_start),
   .mem_wr      (mem_wr)
);

// File: tb/snoop_resp_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_resp_ctrl_tb;

   localparam int TW = 3;
   localparam int BW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_cmd = 2'd0;
   logic [TW-1:0] req_tag = '0;
   logic [1:0] shr_drv = '0, mod_drv = '0, inh_drv = '0;
   logic snp_shared, snp_modified, snp_inhibit;
   logic mem_rdy = 1'b0;
   logic [TW-1:0] mem_rdy_tag = '0;
   logic dbus_grant = 1'b0;
   logic grant_en = 1'b1;
   logic bus_dvalid = 1'b0;
   logic [TW-1:0] bus_dtag = '0;
   logic dbus_req, dbus_drive, fetch_start, fetch_abort, mem_wr;
   logic [TW-1:0] drive_tag, fetch_tag, abort_tag, mem_wr_tag;
   logic [BW-1:0] drive_beat, mem_wr_beat;

   // wired-OR snoop lines built from per-agent drives
   assign snp_shared   = |shr_drv;
   assign snp_modified = |mod_drv;
   assign snp_inhibit  = |inh_drv;

   always #2.5 clk = ~clk;

   snoop_resp_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd), .req_tag(req_tag),
      .snp_shared(snp_shared), .snp_modified(snp_modified), .snp_inhibit(snp_inhibit),
      .mem_rdy(mem_rdy), .mem_rdy_tag(mem_rdy_tag), .dbus_grant(dbus_grant),
      .bus_dvalid(bus_dvalid), .bus_dtag(bus_dtag),
      .dbus_req(dbus_req), .dbus_drive(dbus_drive), .drive_tag(drive_tag), .drive_beat(drive_beat),
      .fetch_start(fetch_start), .fetch_tag(fetch_tag), .fetch_abort(fetch_abort),
      .abort_tag(abort_tag), .mem_wr(mem_wr), .mem_wr_tag(mem_wr_tag), .mem_wr_beat(mem_wr_beat)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // ---------------- reference model ----------------
   int sst[8];     // 0 free, 1 settle, 2 fetching, 3 ready
   bit srd[8];
   int es = 0, etag = 0, ebeat = 0;
   bit cact = 0, cwr = 0;
   int ctag = 0, ccnt = 0;
   bit x_fetch = 0, x_abort = 0, x_wr = 0;
   int x_ftag = 0, x_atag = 0, x_wtag = 0, x_wbeat = 0;

   initial for (int i = 0; i < 8; i++) begin sst[i] = 0; srd[i] = 0; end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) begin sst[i] = 0; srd[i] = 0; end
         es = 0; etag = 0; ebeat = 0; cact = 0; cwr = 0; ctag = 0; ccnt = 0;
         x_fetch = 0; x_abort = 0; x_wr = 0;
      end else begin
         bit fl, serve, any;
         int pick;
         bit dat;
         fl = !cact && bus_dvalid && snp_modified && (sst[bus_dtag] != 0);
         serve = (es == 2) && (ebeat == 3);
         any = 0; pick = 0;
         for (int i = 7; i >= 0; i--) if (sst[i] == 3) begin any = 1; pick = i; end
         dat = req_valid && (req_cmd == 2'd1 || req_cmd == 2'd2);
         // capture
         x_abort = fl; x_wr = 0;
         if (fl) begin
            x_atag = bus_dtag; cwr = srd[bus_dtag]; ctag = bus_dtag; cact = 1; ccnt = 1;
            x_wr = cwr; x_wtag = ctag; x_wbeat = 0;
         end else if (cact && bus_dvalid) begin
            x_wr = cwr; x_wtag = ctag; x_wbeat = ccnt;
            if (ccnt == 3) cact = 0; else ccnt++;
         end
         // engine
         case (es)
            0: if (any && !snp_inhibit && !bus_dvalid) begin es = 1; etag = pick; end
            1: if (snp_inhibit || bus_dvalid) es = 0;
               else if (dbus_grant) begin es = 2; ebeat = 0; end
            2: if (ebeat == 3) es = 3; else ebeat++;
            default: es = 0;
         endcase
         // slots
         for (int i = 0; i < 8; i++) begin
            if (fl && bus_dtag == i[TW-1:0]) sst[i] = 0;
            else case (sst[i])
               0: if (dat && req_tag == i[TW-1:0]) begin sst[i] = 1; srd[i] = (req_cmd == 2'd1); end
               1: sst[i] = (mem_rdy && mem_rdy_tag == i[TW-1:0]) ? 3 : 2;
               2: if (mem_rdy && mem_rdy_tag == i[TW-1:0]) sst[i] = 3;
               default: if (serve && etag == i) sst[i] = 0;
            endcase
         end
         x_fetch = dat; x_ftag = req_tag;
      end
   end

   // ---------------- compare and observe ----------------
   int drv_beats[8];
   int wr_count[8];
   int abort_count = 0;
   int req_cycles = 0;
   int first_tags[$];

   initial for (int i = 0; i < 8; i++) begin drv_beats[i] = 0; wr_count[i] = 0; end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(fetch_start == x_fetch, "R2 fetch_start", fetch_start, x_fetch);
         if (x_fetch) chk(fetch_tag == x_ftag[TW-1:0], "R2 fetch_tag", fetch_tag, x_ftag);
         chk(dbus_req == (es == 1), "R3/R4/R6 dbus_req", dbus_req, es == 1);
         chk(dbus_drive == (es == 2), "R5 dbus_drive", dbus_drive, es == 2);
         if (es == 2) begin
            chk(drive_tag == etag[TW-1:0], "R5/R10 drive_tag", drive_tag, etag);
            chk(drive_beat == ebeat[BW-1:0], "R5 drive_beat", drive_beat, ebeat);
         end
         chk(fetch_abort == x_abort, "R7/R12 fetch_abort", fetch_abort, x_abort);
         if (x_abort) chk(abort_tag == x_atag[TW-1:0], "R7 abort_tag", abort_tag, x_atag);
         chk(mem_wr == x_wr, "R8/R9 mem_wr", mem_wr, x_wr);
         if (x_wr) begin
            chk(mem_wr_tag == x_wtag[TW-1:0], "R8 mem_wr_tag", mem_wr_tag, x_wtag);
            chk(mem_wr_beat == x_wbeat[BW-1:0], "R8 mem_wr_beat", mem_wr_beat, x_wbeat);
         end
         if (dbus_drive) begin
            drv_beats[drive_tag]++;
            if (drive_beat == 0) first_tags.push_back(int'(drive_tag));
         end
         if (mem_wr) wr_count[mem_wr_tag]++;
         if (fetch_abort) abort_count++;
         if (dbus_req) req_cycles++;
      end
      dbus_grant = grant_en && dbus_req;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         report();
      end
   end

   // ---------------- stimulus ----------------
   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(input int cmd, input int tag);
      req_valid = 1; req_cmd = cmd[1:0]; req_tag = tag[TW-1:0];
      tick();
      req_valid = 0; req_cmd = 2'd0;
   endtask

   task automatic ready(input int tag);
      mem_rdy = 1; mem_rdy_tag = tag[TW-1:0];
      tick();
      mem_rdy = 0;
   endtask

   task automatic flush(input int tag, input int agent);
      inh_drv[agent] = 0; mod_drv[agent] = 1; bus_dvalid = 1; bus_dtag = tag[TW-1:0];
      tick();
      mod_drv[agent] = 0;
      tick(3);
      bus_dvalid = 0;
      tick();
   endtask

   initial begin
      tick(3);
      // R1: outputs low under reset
      chk({dbus_req, dbus_drive, fetch_start, fetch_abort, mem_wr} == 5'b0, "R1 reset", 1, 0);
      rst_n = 1;
      tick();
      chk({dbus_req, dbus_drive, fetch_start, fetch_abort, mem_wr} == 5'b0, "R1 after reset", 1, 0);

      // R2/R4/R5/R6: clean read served by memory
      issue(1, 1);
      tick();
      ready(1);
      tick(12);
      chk(drv_beats[1] == 4, "R5 burst length tag1", drv_beats[1], 4);

      // R7/R8: read owned modified by a cache, inhibit held then flush
      issue(1, 2);
      inh_drv[0] = 1;
      tick();
      ready(2);
      req_cycles = 0;
      tick(6);
      chk(req_cycles == 0, "R3 no request under inhibit", req_cycles, 0);
      abort_count = 0;
      flush(2, 0);
      tick(6);
      chk(abort_count == 1, "R7 one abort tag2", abort_count, 1);
      chk(wr_count[2] == 4, "R8 writeback beats tag2", wr_count[2], 4);
      chk(drv_beats[2] == 0, "R7 memory silent tag2", drv_beats[2], 0);

      // R9: read-exclusive owned modified
      issue(2, 3);
      inh_drv[1] = 1;
      tick();
      ready(3);
      tick(4);
      flush(3, 1);
      tick(6);
      chk(wr_count[3] == 0, "R9 no writeback tag3", wr_count[3], 0);
      chk(drv_beats[3] == 0, "R7 memory silent tag3", drv_beats[3], 0);

      // R10/R11: two ready slots, shared asserted throughout
      shr_drv[1] = 1;
      inh_drv[0] = 1;
      issue(1, 5);
      issue(2, 4);
      tick();
      ready(5);
      ready(4);
      tick(2);
      first_tags.delete();
      inh_drv[0] = 0;
      tick(20);
      chk(first_tags.size() == 2, "R10 two bursts", first_tags.size(), 2);
      if (first_tags.size() == 2) begin
         chk(first_tags[0] == 4, "R10 lowest first", first_tags[0], 4);
         chk(first_tags[1] == 5, "R10 then next", first_tags[1], 5);
      end
      chk(drv_beats[5] == 4, "R11 shared ignored tag5", drv_beats[5], 4);
      shr_drv[1] = 0;

      // R2: upgrade starts nothing
      issue(3, 6);
      tick(3);
      // R12: flush on a free tag is ignored
      abort_count = 0;
      flush(6, 1);
      tick(3);
      chk(abort_count == 0, "R12 no abort free tag", abort_count, 0);
      chk(wr_count[6] == 0, "R12 no write free tag", wr_count[6], 0);

      // R13: ready on a free tag
      req_cycles = 0;
      ready(7);
      tick(6);
      chk(req_cycles == 0, "R13 stray ready ignored", req_cycles, 0);

      report();
   end

endmodule